// File: doc/BRIEF.md
# Keyed Register Write-Protect Unit

This block sits in front of a peripheral's register file and stops stray software writes from corrupting it. It watches a plain register bus made of a word address, a write strobe with write data, and a read strobe with registered read data. A mode register holds a protection enable bit and takes a 24-bit access key. While protection is on, every write that lands in the register window is dropped unless it targets the mode register itself. Each dropped write raises a sticky violation flag and records the word address it aimed at.

The flag can only be cleared by a mode-register write that carries the correct key. A write with a wrong key changes nothing. The protected registers are modelled as a small scratch array so that blocking can be seen at the ports. The whole window, from byte offset 0x000 to 0x1FC, is addressed here as word addresses 0x00 to 0x7F, where the word address is byte offset bits 8:2.

The bus has no back-pressure. Every read or write is accepted in the cycle its strobe is high. Read data arrives one cycle later, qualified by a valid pulse, and there is no ready signal to stall it.

Top module: `wp_guard`

## Requirements
- R1: After reset, protection is off, the violation flag and source field read 0, and every scratch word reads 0.
- R2: With protection off, a write to scratch word addresses 0..NUM_SCRATCH-1 stores its data and leaves the violation flag clear.
- R3: With protection on, a write to any scratch word leaves that word's contents unchanged.
- R4: With protection on, a write to any word address other than the mode register (0x79) sets the violation flag, which is status bit 0.
- R5: On every blocked write, the status source field (status bits 14:8) takes the targeted word address, so after several violations it holds the most recent one.
- R6: The violation flag is sticky. Further writes do not clear it, and reading the status register (0x7A) does not clear it.
- R7: A write to the mode register whose bits 31:8 equal 0x4D4154 loads the enable from bit 0 and clears the violation flag. The mode register reads back the enable in bit 0 and zeros elsewhere.
- R8: A write to the mode register with any other value in bits 31:8 leaves the enable, the flag and the source field unchanged.
- R9: The mode register is never blocked. The status register is read-only: a write to it never changes its contents apart from the violation record that R4 and R5 define.
- R10: A read strobe produces rd_valid with the addressed value exactly one cycle later. Unmapped word addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Word address (byte offset bits 8:2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after rd_en |

## Verification
A stuck or mis-set enable shows on the next mode-register read, and one write later as a scratch word that changed or did not change. A lost or falsely set flag, or a stale source field, shows on the first status read after the offending write, two cycles after that write. A key comparator that accepts wrong keys shows on the next mode or status read, as an enable that changed or a flag that was cleared.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    TGT_SCRATCH = 2'd0,
    TGT_MODE    = 2'd1,
    TGT_STATUS  = 2'd2,
    TGT_NONE    = 2'd3
  } tgt_e;
endpackage

// File: rtl/wp_decode.sv
module wp_decode
  import wp_pkg::*;
#(
  parameter int AW          = 7,
  parameter int NUM_SCRATCH = 8,
  parameter logic [AW-1:0] MODE_IDX = 7'h79,
  parameter logic [AW-1:0] STAT_IDX = 7'h7A
) (
  input  logic [AW-1:0] idx,
  output tgt_e          tgt
);
  localparam logic [AW-1:0] SCR_LIM = AW'(NUM_SCRATCH);

  always_comb begin
    if (idx == MODE_IDX)      tgt = TGT_MODE;
    else if (idx == STAT_IDX) tgt = TGT_STATUS;
    else if (idx < SCR_LIM)   tgt = TGT_SCRATCH;
    else                      tgt = TGT_NONE;
  end
endmodule

// File: rtl/wp_state.sv
module wp_state
  import wp_pkg::*;
#(
  parameter int AW    = 7,
  parameter int KEY_W = 24,
  parameter logic [KEY_W-1:0] KEY = 24'h4D4154
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  tgt_e             tgt,
  input  logic [AW-1:0]    idx,
  input  logic             en_bit,
  input  logic [KEY_W-1:0] key_in,
  output logic             prot_en,
  output logic             flag,
  output logic [AW-1:0]    src,
  output logic             wr_blocked
);
  logic mode_wr, key_ok;

  assign mode_wr    = wr_en && (tgt == TGT_MODE);
  assign key_ok     = (key_in == KEY);
  assign wr_blocked = wr_en && prot_en && (tgt != TGT_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_en <= 1'b0;
      flag    <= 1'b0;
      src     <= '0;
    end else if (mode_wr && key_ok) begin
      prot_en <= en_bit;
      flag    <= 1'b0;
    end else if (wr_blocked) begin
      flag <= 1'b1;
      src  <= idx;
    end
  end

  assert_viol_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> flag);
  assert_src_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> (src == $past(idx)));
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(mode_wr && key_ok)) |=> flag);
  assert_bad_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !key_ok) |=> ($stable(prot_en) && $stable(flag) && $stable(src)));
  assert_key_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && key_ok) |=> (!flag && (prot_en == $past(en_bit))));
endmodule

// File: rtl/wp_scratch.sv
module wp_scratch #(
  parameter int DW  = 32,
  parameter int NUM = 8,
  parameter int SW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q [NUM]
);
  for (genvar i = 0; i < NUM; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         q[i] <= '0;
      else if (we && (sel == SW'(i)))     q[i] <= wdata;
    end
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int AW          = 7,
  parameter int DW          = 32,
  parameter int NUM_SCRATCH = 8,
  parameter logic [AW-1:0] MODE_IDX = 7'h79,
  parameter logic [AW-1:0] STAT_IDX = 7'h7A,
  parameter logic [DW-9:0] KEY      = 24'h4D4154
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_valid
);
  localparam int KEY_W = DW - 8;
  localparam int SW    = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1;
  localparam int SRC_LSB = 8;

  tgt_e          tgt;
  logic          prot_en, flag, wr_blocked, scr_we;
  logic [AW-1:0] src;
  logic [DW-1:0] scr_q [NUM_SCRATCH];
  logic [DW-1:0] rd_next;
  logic [SW-1:0] sel;

  assign sel = addr[SW-1:0];

  wp_decode #(.AW(AW), .NUM_SCRATCH(NUM_SCRATCH), .MODE_IDX(MODE_IDX), .STAT_IDX(STAT_IDX))
    u_dec (.idx(addr), .tgt(tgt));

  wp_state #(.AW(AW), .KEY_W(KEY_W), .KEY(KEY)) u_state (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tgt(tgt), .idx(addr),
    .en_bit(wdata[0]), .key_in(wdata[DW-1:8]),
    .prot_en(prot_en), .flag(flag), .src(src), .wr_blocked(wr_blocked));

  assign scr_we = wr_en && (tgt == TGT_SCRATCH) && !wr_blocked;

  wp_scratch #(.DW(DW), .NUM(NUM_SCRATCH), .SW(SW)) u_scr (
    .clk(clk), .rst_n(rst_n), .we(scr_we), .sel(sel), .wdata(wdata), .q(scr_q));

  always_comb begin
    rd_next = '0;
    case (tgt)
      TGT_SCRATCH: rd_next = scr_q[sel];
      TGT_MODE:    rd_next[0] = prot_en;
      TGT_STATUS: begin
        rd_next[0] = flag;
        rd_next[SRC_LSB +: AW] = src;
      end
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_next;
    end
  end

  assert_rd_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  for (genvar i = 0; i < NUM_SCRATCH; i++) begin : g_chk
    assert_blocked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && prot_en && (addr == AW'(i))) |=> $stable(scr_q[i]));
    assert_open_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !prot_en && (addr == AW'(i))) |=> (scr_q[i] == $past(wdata)));
  end
endmodule

// File: tb/wp_guard_test.sv
module wp_guard_test;
  localparam logic [6:0]  MODE = 7'h79;
  localparam logic [6:0]  STAT = 7'h7A;
  localparam logic [23:0] KEY  = 24'h4D4154;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [6:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rd_valid;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  logic        m_en = 1'b0, m_flag = 1'b0;
  logic [6:0]  m_src = '0;
  logic [31:0] m_scr [8];

  always #5 clk = ~clk;

  wp_guard uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid));

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    if (a == MODE) begin
      if (d[31:8] == KEY) begin m_en = d[0]; m_flag = 1'b0; end
    end else if (m_en) begin
      m_flag = 1'b1; m_src = a;
    end else if (a < 7'd8) begin
      m_scr[a[2:0]] = d;
    end
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input string tag);
    logic [31:0] e;
    e = '0;
    if (a == MODE) e[0] = m_en;
    else if (a == STAT) begin e[0] = m_flag; e[14:8] = m_src; end
    else if (a < 7'd8) e = m_scr[a[2:0]];
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++; $display("FAIL R10: unexpected rd_valid, rdata=%h expected no read", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++; $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_scr[i] = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0) begin errors++; $display("FAIL R10: rd_valid=%b expected 0 in reset", rd_valid); end
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 8; i++) rd(7'(i), "R1");
    rd(MODE, "R1"); rd(STAT, "R1");
    rd(7'h40, "R10");
    // R2 open writes
    for (int i = 0; i < 8; i++) wr(7'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101));
    for (int i = 0; i < 8; i++) rd(7'(i), "R2");
    rd(STAT, "R2");
    // R7 enable with key
    wr(MODE, {KEY, 8'h01}); rd(MODE, "R7"); rd(STAT, "R7");
    // R3/R4/R5 blocked write
    wr(7'd3, 32'hDEADBEEF); rd(7'd3, "R3"); rd(STAT, "R4");
    wr(7'h50, 32'h1); rd(STAT, "R5");
    rd(STAT, "R6"); rd(STAT, "R6");
    wr(7'd6, 32'h0); rd(7'd6, "R3"); rd(STAT, "R5");
    // R9 status write counts as violation, contents not overwritten
    wr(STAT, 32'hFFFFFFFF); rd(STAT, "R9");
    // R8 wrong keys
    wr(MODE, {24'h123456, 8'h00}); rd(MODE, "R8"); rd(STAT, "R8");
    wr(MODE, {24'h4D4155, 8'h00}); rd(MODE, "R8"); rd(STAT, "R8");
    // R7 correct key, keep enabled, flag cleared
    wr(MODE, {KEY, 8'h01}); rd(STAT, "R7"); rd(MODE, "R7");
    wr(7'd0, 32'h12345678); rd(7'd0, "R3"); rd(STAT, "R6");
    // R7 disable
    wr(MODE, {KEY, 8'h00}); rd(MODE, "R7"); rd(STAT, "R7");
    wr(7'd5, 32'hCAFEF00D); rd(7'd5, "R2"); rd(STAT, "R2");
    // R9 status write while disabled does nothing
    wr(STAT, 32'hFFFFFFFF); rd(STAT, "R9");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++; $display("FAIL R10: %0d reads unanswered expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule